// File: doc/BRIEF.md
# MAC Accumulator Readout Converter

This block turns a 48-bit two's-complement accumulator value from a multiply-accumulate unit into a 32-bit register result. A 2-bit mode picks how the value is read. Fractional readout drops the guard and fraction bits below the result, rounds half-to-even and then either saturates or wraps. Signed integer readout clamps to the 32-bit signed range. Unsigned integer readout clamps to the 32-bit unsigned range.

Three control flags come from the unit's status register. A 16-bit select chooses a 16-bit fractional result taken from bits 39..24. A rounding enable turns on ties-to-even rounding for the 32-bit fractional result. A saturation enable decides what happens when the rounded value overflows the target width. Each conversion starts on a one-cycle valid strobe, and the result comes out on a registered port one clock later with its own valid pulse.

Top module: `mac_readout`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` changes only in that cycle and holds its value while `in_valid` is low.
- R3: When `mode` is 2'b00 and `frac16` is 1, the output is formed this way. `result[15:0]` is the signed value of accumulator bits 47..24, rounded by the low 24 bits: add one when the remainder is above 0x800000, and add the quotient's LSB when it equals 0x800000. This rounding applies whatever `round_en` holds. `result[31:16]` is 0.
- R4: When `mode` is 2'b00, `frac16` is 0 and `round_en` is 1, the output is the accumulator shifted arithmetically right by 8. The low 8 bits act as remainder with the same rule: add one above 0x80, and add the LSB at exactly 0x80.
- R5: When `mode` is 2'b00, `frac16` is 0 and `round_en` is 0, the output is the accumulator shifted arithmetically right by 8 with no rounding.
- R6: When `sat_en` is 1 and the rounded fractional value is outside the signed target range, the output saturates by sign. In 16-bit mode the result is 0x00007FFF or 0x00008000. In 32-bit mode it is 0x7FFFFFFF or 0x80000000.
- R7: When `sat_en` is 0, the fractional result is the low 16 bits (16-bit mode, zero-extended) or the low 32 bits of the rounded value.
- R8: When `mode` is 2'b01 (signed integer), the output is the low 32 bits if the accumulator is within −2^31..2^31−1. Otherwise it is 0x7FFFFFFF for a positive value and 0x80000000 for a negative one.
- R9: When `mode` is 2'b10 (unsigned integer), the output is 0xFFFFFFFF if any accumulator bit 47..32 is set, and the low 32 bits otherwise.
- R10: When `mode` is 2'b11 (reserved), the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Conversion strobe |
| mode | input | 2 | 00 fractional, 01 signed integer, 10 unsigned integer, 11 reserved |
| frac16 | input | 1 | Fractional result is 16 bits |
| round_en | input | 1 | Round the 32-bit fractional result |
| sat_en | input | 1 | Saturate fractional overflow |
| acc | input | 48 | Accumulator value, two's complement |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 32 | Converted value |

## Verification
Each fault shows up at the ports on the valid cycle that follows the faulty conversion. Fractional errors show up in the low bits:
- a wrong tie decision leaves the result one unit off, and only on exact half remainders, so the bench builds those remainders on purpose with both quotient parities and both signs;
- a wrong overflow test shows up only where a rounding carry crosses the signed limit.

A broken clamp in the integer paths shows up only next to bits 31 and 32, so the directed vectors sit on each side of those limits. The random vectors are biased toward small magnitudes to reach them often.

// File: rtl/mac_readout_pkg.sv
// Package: shared widths and mode encoding for the accumulator readout.
// Assumes a two's-complement accumulator and a 32-bit register result.
package mac_readout_pkg;
    localparam int ACC_W = 48;
    localparam int RES_W = 32;
    localparam int F16_W = 16;
    localparam int F16_SHIFT = 24;
    localparam int F32_SHIFT = 8;

    typedef enum logic [1:0] {
        RD_FRAC = 2'b00,
        RD_SINT = 2'b01,
        RD_UINT = 2'b10,
        RD_RSVD = 2'b11
    } rd_mode_e;
endpackage

// File: rtl/mac_round_sat.sv
// Module: one fractional readout lane. It drops SHIFT low bits by arithmetic
// shift and optionally rounds half-to-even on them. It then saturates to a
// signed OUT_W range or wraps to OUT_W bits.
// Assumes IN_W - SHIFT > OUT_W, so that a spare bit remains to detect overflow.
module mac_round_sat #(
    parameter int IN_W  = 48,
    parameter int SHIFT = 8,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    input  logic             rnd_i,
    input  logic             sat_i,
    output logic [OUT_W-1:0] res_o
);
    localparam int QW = IN_W - SHIFT;
    localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    logic [QW:0]      quo;
    logic [SHIFT-1:0] rem;
    logic             bump;
    logic [QW:0]      rnd;
    logic [QW-OUT_W+1:0] top;
    logic             fits;

    // Split the value into a sign-extended quotient and its remainder, then round.
    always_comb begin
        quo  = {val_i[IN_W-1], val_i[IN_W-1:SHIFT]};
        rem  = val_i[SHIFT-1:0];
        bump = rnd_i && ((rem > HALF) || ((rem == HALF) && quo[0]));
        rnd  = quo + {{QW{1'b0}}, bump};
    end

    // Check the signed range, then pick the limit or the wrapped low bits.
    always_comb begin
        top  = rnd[QW:OUT_W-1];
        fits = (&top) || !(|top);
        if (sat_i && !fits)
            res_o = rnd[QW] ? NEG_LIM : POS_LIM;
        else
            res_o = rnd[OUT_W-1:0];
    end
endmodule

// File: rtl/mac_int_clamp.sv
// Module: integer readout of the accumulator. It gives a signed clamp and an
// unsigned clamp to OUT_W bits in parallel. Assumes IN_W > OUT_W.
module mac_int_clamp #(
    parameter int IN_W  = 48,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] sres_o,
    output logic [OUT_W-1:0] ures_o
);
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    logic [IN_W-OUT_W:0]   shi;
    logic [IN_W-OUT_W-1:0] uhi;

    // Signed clamp: the value fits when the bits above the sign all match it.
    always_comb begin
        shi = val_i[IN_W-1:OUT_W-1];
        if ((&shi) || !(|shi))
            sres_o = val_i[OUT_W-1:0];
        else
            sres_o = val_i[IN_W-1] ? NEG_LIM : POS_LIM;
    end

    // Unsigned clamp: any bit above the result width forces all ones.
    always_comb begin
        uhi    = val_i[IN_W-1:OUT_W];
        ures_o = (|uhi) ? {OUT_W{1'b1}} : val_i[OUT_W-1:0];
    end
endmodule

// File: rtl/mac_readout.sv
// Module: top of the accumulator readout. It runs both fractional lanes and
// the integer clamps side by side, selects one by mode and registers the
// result one cycle after the strobe. Assumes the mode and flags are stable
// in the cycle of the strobe.
module mac_readout
    import mac_readout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic             frac16,
    input  logic             round_en,
    input  logic             sat_en,
    input  logic [ACC_W-1:0] acc,
    output logic             out_valid,
    output logic [RES_W-1:0] result
);
    localparam int PAD16 = RES_W - F16_W;

    logic [F16_W-1:0] f16_res;
    logic [RES_W-1:0] f32_res;
    logic [RES_W-1:0] s_res;
    logic [RES_W-1:0] u_res;
    logic [RES_W-1:0] nxt;
    rd_mode_e         sel;

    // 16-bit lane: rounding always on.
    mac_round_sat #(.IN_W(ACC_W), .SHIFT(F16_SHIFT), .OUT_W(F16_W)) u_f16 (
        .val_i(acc), .rnd_i(1'b1), .sat_i(sat_en), .res_o(f16_res)
    );

    // 32-bit lane: rounding under control of round_en.
    mac_round_sat #(.IN_W(ACC_W), .SHIFT(F32_SHIFT), .OUT_W(RES_W)) u_f32 (
        .val_i(acc), .rnd_i(round_en), .sat_i(sat_en), .res_o(f32_res)
    );

    mac_int_clamp #(.IN_W(ACC_W), .OUT_W(RES_W)) u_int (
        .val_i(acc), .sres_o(s_res), .ures_o(u_res)
    );

    // Pick the lane named by the mode.
    always_comb begin
        sel = rd_mode_e'(mode);
        unique case (sel)
            RD_FRAC: nxt = frac16 ? {{PAD16{1'b0}}, f16_res} : f32_res;
            RD_SINT: nxt = s_res;
            RD_UINT: nxt = u_res;
            default: nxt = '0;
        endcase
    end

    // Output register: load on the strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= nxt;
        end
    end

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !in_valid) |-> $stable(result));

    p_f16_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && mode == 2'b00 && frac16) |-> (result[RES_W-1:F16_W] == '0));

    p_uint_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && mode == 2'b10 && (|acc[ACC_W-1:RES_W])) |-> (&result));

    p_sint_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && mode == 2'b01 &&
              ((&acc[ACC_W-1:RES_W-1]) || !(|acc[ACC_W-1:RES_W-1])))
        |-> (result == $past(acc[RES_W-1:0])));

    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && mode == 2'b11) |-> (result == '0));
endmodule

// File: tb/mac_readout_test.sv
module mac_readout_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        frac16 = 1'b0;
    logic        round_en = 1'b0;
    logic        sat_en = 1'b0;
    logic [47:0] acc = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mac_readout uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .frac16(frac16), .round_en(round_en), .sat_en(sat_en), .acc(acc),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model(logic [47:0] a, logic [1:0] m,
                                          logic f16, logic rnd, logic sat);
        longint v = longint'($signed(a));
        longint q;
        longint r;
        if (m == 2'b11) return 32'h0;
        if (m == 2'b10) return (a[47:32] != 0) ? 32'hFFFFFFFF : a[31:0];
        if (m == 2'b01) begin
            if (v > 64'sd2147483647)  return 32'h7FFFFFFF;
            if (v < -64'sd2147483648) return 32'h80000000;
            return a[31:0];
        end
        if (f16) begin
            q = v >>> 24;
            r = v & 64'hFFFFFF;
            if (r > 64'h800000) q = q + 1;
            else if (r == 64'h800000) q = q + (q & 1);
            if (sat && q > 32767)  return 32'h00007FFF;
            if (sat && q < -32768) return 32'h00008000;
            return {16'h0, q[15:0]};
        end
        q = v >>> 8;
        r = v & 64'hFF;
        if (rnd) begin
            if (r > 64'h80) q = q + 1;
            else if (r == 64'h80) q = q + (q & 1);
        end
        if (sat && q > 64'sd2147483647)  return 32'h7FFFFFFF;
        if (sat && q < -64'sd2147483648) return 32'h80000000;
        return q[31:0];
    endfunction

    function automatic string req_of(logic [1:0] m, logic f16, logic rnd);
        if (m == 2'b11) return "R10";
        if (m == 2'b10) return "R9";
        if (m == 2'b01) return "R8";
        if (f16) return "R3/R6/R7";
        return rnd ? "R4/R6/R7" : "R5/R6/R7";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic apply(logic [47:0] a, logic [1:0] m, logic f16, logic rnd, logic sat);
        logic [31:0] e;
        e = model(a, m, f16, rnd, sat);
        @(negedge clk);
        acc = a; mode = m; frac16 = f16; round_en = rnd; sat_en = sat;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {31'b0, out_valid}, 32'h1);
        check(req_of(m, f16, rnd), result, e);
    endtask

    task automatic hold_check();
        logic [31:0] prev;
        prev = result;
        @(negedge clk);
        acc = ~acc; mode = mode + 2'd1; frac16 = ~frac16;
        @(negedge clk);
        check("R2 idle valid", {31'b0, out_valid}, 32'h0);
        check("R2 hold", result, prev);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] rv;
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'b0, out_valid}, 32'h0);
        check("R1 result", result, 32'h0);
        rst_n = 1'b1;

        // R4 ties to even, both parities and signs
        apply(48'h000000000180, 2'b00, 1'b0, 1'b1, 1'b1);
        apply(48'h000000000080, 2'b00, 1'b0, 1'b1, 1'b1);
        apply(48'h000000000181, 2'b00, 1'b0, 1'b1, 1'b1);
        apply(48'h00000000017F, 2'b00, 1'b0, 1'b1, 1'b1);
        apply(48'hFFFFFFFFFF80, 2'b00, 1'b0, 1'b1, 1'b1);
        apply(48'hFFFFFFFFFE80, 2'b00, 1'b0, 1'b1, 1'b0);
        // R5 truncation
        apply(48'h0000000001FF, 2'b00, 1'b0, 1'b0, 1'b1);
        apply(48'hFFFFFFFFFFFF, 2'b00, 1'b0, 1'b0, 1'b1);
        hold_check();
        // R3 16-bit ties, rounding flag ignored
        apply(48'h000001800000, 2'b00, 1'b1, 1'b0, 1'b1);
        apply(48'h000002800000, 2'b00, 1'b1, 1'b0, 1'b1);
        apply(48'hFFFFFF800000, 2'b00, 1'b1, 1'b1, 1'b1);
        apply(48'h000001800001, 2'b00, 1'b1, 1'b0, 1'b0);
        // R6 saturation, including a rounding carry across the limit
        apply(48'h7FFFFFFFFF00, 2'b00, 1'b0, 1'b0, 1'b1);
        apply(48'h007FFFFFFFFF, 2'b00, 1'b0, 1'b1, 1'b1);
        apply(48'h800000000000, 2'b00, 1'b0, 1'b1, 1'b1);
        apply(48'h008000000000, 2'b00, 1'b1, 1'b0, 1'b1);
        apply(48'hFF0000000000, 2'b00, 1'b1, 1'b0, 1'b1);
        apply(48'h007FFFFFFFFF, 2'b00, 1'b1, 1'b0, 1'b1);
        // R7 wrap without saturation
        apply(48'h7FFFFFFFFF00, 2'b00, 1'b0, 1'b0, 1'b0);
        apply(48'h008000000000, 2'b00, 1'b1, 1'b0, 1'b0);
        apply(48'h007FFFFFFFFF, 2'b00, 1'b0, 1'b1, 1'b0);
        // R8 signed clamp edges
        apply(48'h00007FFFFFFF, 2'b01, 1'b0, 1'b0, 1'b0);
        apply(48'h000080000000, 2'b01, 1'b0, 1'b0, 1'b0);
        apply(48'hFFFF80000000, 2'b01, 1'b0, 1'b0, 1'b0);
        apply(48'hFFFF7FFFFFFF, 2'b01, 1'b0, 1'b0, 1'b0);
        // R9 unsigned clamp edges
        apply(48'h0000FFFFFFFF, 2'b10, 1'b0, 1'b0, 1'b0);
        apply(48'h000100000000, 2'b10, 1'b0, 1'b0, 1'b0);
        apply(48'h800000000000, 2'b10, 1'b0, 1'b0, 1'b0);
        // R10 reserved mode
        apply(48'h123456789ABC, 2'b11, 1'b0, 1'b1, 1'b1);
        hold_check();

        // Constrained random: mixed magnitudes around the limits
        for (int i = 0; i < 400; i++) begin
            logic [47:0] a;
            rv = {$urandom, $urandom};
            case (rv[63:62])
                2'd0: a = rv[47:0];
                2'd1: a = {{16{rv[33]}}, rv[31:0]};
                2'd2: a = {{8{rv[40]}}, rv[39:0]};
                default: a = {rv[47:24], (rv[2] ? 24'h800000 : {16'h0, rv[10:9], 6'h0, rv[7:0]})};
            endcase
            apply(a, rv[61:60], rv[59], rv[58], rv[57]);
            if (rv[56] && rv[55]) hold_check();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule